// File: doc/BRIEF.md
# Multi-Channel DMA Register File

This block is the 32-bit memory-mapped register slave of a sixteen-channel DMA controller. For every channel it keeps a control/status word, a control-block address and a debug word. It also shows the channel's current transfer descriptor: the info, source, destination, length, stride and next-block words. The transfer engine loads those descriptor words through a side port, and software can only read them. Two words are shared by all channels: a channel-enable mask and an interrupt-status vector.

Software reaches channels 0 to 14 through a 4 KiB main window. In that window, address bits [11:8] pick the channel and bits [7:0] pick the register. The shared words sit at the top of the same window. Channel 15 has the same register layout but is reached through a separate 256-byte window. When a software write sets a channel's ACTIVE bit, the block emits a one-cycle start pulse for that channel. It drives one interrupt line per channel. The engine reports completion, errors and flow-control state through a status port. The engine also advances the control-block address through a dedicated strobe.

Every access is a full 32-bit word and is answered one cycle later with a ready strobe.

Top module: `dma_regfile`

## Requirements
- R1: With `req_win`=0, word offsets below 0xF00 address channel `addr[11:8]` (0 to 14) at register `addr[7:0]`. With `req_win`=1, `addr[7:0]` addresses channel 15. Any other offset reads as zero and ignores writes. This covers non-word-aligned addresses, register offsets above 0x20, channel field 15 in the main window, and global offsets other than 0xFE0 and 0xFF0.
- R2: Control/status bits are laid out as follows: ACTIVE is bit 0, END is bit 1, INT is bit 2, PAUSED is bit 4, HELD is bit 5 and ERR is bit 8. A write to offset 0x00 replaces exactly the bits in mask 0x30FF0001, and all other bits keep their value.
- R3: Writing 1 to bit 1 (END) at offset 0x00 clears END.
- R4: Writing 1 to bit 2 (INT) at offset 0x00 clears INT, clears the channel's bit in the interrupt-status vector and drops the channel's `irq` line.
- R5: Writing 1 to bit 31 at offset 0x00 zeroes the channel's control/status word and its control-block address. The masked field of the same write then lands. Bits 31 and 30 always read as 0.
- R6: A write to offset 0x00 that takes ACTIVE from 0 to 1 raises `start_pulse[ch]` for exactly one cycle. Any other write raises no pulse.
- R7: Offset 0x04 (control-block address) and offset 0x20 (debug) store and read back all 32 bits.
- R8: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read back, in that order, the info, source, destination, length, stride and next-block words last loaded by `eng_mirror_valid`. Software writes to these offsets have no effect.
- R9: On `eng_stat_valid`, the engine can set END, INT and ERR, and HELD takes the value of `eng_held`. `eng_finish` clears ACTIVE and sets PAUSED. `eng_cb_we` loads the control-block address.
- R10: Offset 0xFE0 in the main window reads the interrupt-status vector, where bit c is channel c's INT bit. Writes to 0xFE0 are ignored. `irq[c]` equals INT of channel c.
- R11: Offset 0xFF0 in the main window holds a 16-bit enable mask, which resets to 0xFFFF and reads with bits [31:16] at zero. The mask drives `chan_enable`.
- R12: Each access cycle is answered with `rsp_ready` high in the next cycle. `rsp_rdata` carries the read value then, and is zero for writes.
- R13: When a software write and an engine update hit the same channel in the same cycle, software wins. A write-one-to-clear beats an engine set of END or INT. The written ACTIVE value beats `eng_finish`. A software write of 0x04 or a reset bit beats `eng_cb_we`.
- R14: After reset, all control/status words and control-block addresses read 0, the interrupt vector is 0, the enable mask is 0xFFFF, and no start pulse or interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = main window, 1 = channel-15 window |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Access completed (one cycle after request) |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| chan_enable | output | 16 | Global channel-enable mask |
| start_pulse | output | 16 | One-cycle start request per channel |
| irq | output | 16 | Interrupt line per channel |
| eng_stat_valid | input | 1 | Engine status update strobe |
| eng_chan | input | 4 | Channel of the engine update |
| eng_set_end | input | 1 | Set END |
| eng_set_int | input | 1 | Set INT |
| eng_set_err | input | 1 | Set ERR |
| eng_finish | input | 1 | Clear ACTIVE, set PAUSED |
| eng_held | input | 1 | New value of HELD |
| eng_mirror_valid | input | 1 | Load descriptor mirror words |
| eng_info | input | 32 | Transfer info word |
| eng_src | input | 32 | Source address |
| eng_dst | input | 32 | Destination address |
| eng_len | input | 32 | Remaining length |
| eng_stride | input | 32 | Stride word |
| eng_next | input | 32 | Next control-block address |
| eng_cb_we | input | 1 | Load control-block address |
| eng_cb_addr | input | 32 | New control-block address |

## Verification
An engine status update and a software write to the same channel's control/status word can fall in the same cycle. So can an engine control-block advance and a software write of the address register. The bench provokes both cases directly. It sets INT and END from the engine in the cycle in which software clears them, and it finishes a channel in the cycle in which software rewrites ACTIVE to 1. The random phase also mixes engine and bus traffic freely on colliding channels. Results are judged against a bench model that applies the engine update first and the software write second. Through ordinary reads, the bench then expects the cleared bits to stay clear, ACTIVE to stay set, and the written address to survive.

// File: rtl/dma_rf_pkg.sv
// Package: shared encodings for the DMA register file.
// Assumes a 32-bit data path; bit positions below are fixed by the
// software-visible layout of the control/status word.
package dma_rf_pkg;

    typedef enum logic [3:0] {
        SEL_CS, SEL_CBA, SEL_INFO, SEL_SRC, SEL_DST, SEL_LEN,
        SEL_STRIDE, SEL_NEXT, SEL_DBG, SEL_INTVEC, SEL_ENMASK, SEL_NONE
    } reg_sel_e;

    localparam logic [31:0] CS_RW_MASK = 32'h30FF_0001;

    localparam int B_ACTIVE = 0;
    localparam int B_END    = 1;
    localparam int B_INT    = 2;
    localparam int B_PAUSED = 4;
    localparam int B_HELD   = 5;
    localparam int B_ERR    = 8;
    localparam int B_SRST   = 31;

    localparam logic [11:0] OFF_GLOBAL = 12'hF00;
    localparam logic [11:0] OFF_INTVEC = 12'hFE0;
    localparam logic [11:0] OFF_ENMASK = 12'hFF0;

    // Map an in-window register offset to a register selector.
    function automatic reg_sel_e chan_reg_sel(input logic [7:0] off);
        case (off)
            8'h00:   return SEL_CS;
            8'h04:   return SEL_CBA;
            8'h08:   return SEL_INFO;
            8'h0C:   return SEL_SRC;
            8'h10:   return SEL_DST;
            8'h14:   return SEL_LEN;
            8'h18:   return SEL_STRIDE;
            8'h1C:   return SEL_NEXT;
            8'h20:   return SEL_DBG;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_rf_decode.sv
// Module: address decoder.
// Turns window select and byte offset into a channel index and a register
// selector. Assumes word accesses only: any offset with bits [1:0] set
// decodes to SEL_NONE. The last channel is reachable only via window 1.
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned AW  = 12,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  logic           win,
    input  logic [AW-1:0]  addr,
    output logic [CHW-1:0] chan,
    output reg_sel_e       sel
);
    localparam int unsigned LOCW = 8;

    // Combinational decode of window, channel field and register offset.
    always_comb begin
        chan = '0;
        sel  = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (win) begin
                chan = CHW'(NCH - 1);
                sel  = chan_reg_sel(addr[LOCW-1:0]);
            end else if (addr < AW'(OFF_GLOBAL)) begin
                if (addr[LOCW +: CHW] < CHW'(NCH - 1)) begin
                    chan = addr[LOCW +: CHW];
                    sel  = chan_reg_sel(addr[LOCW-1:0]);
                end
            end else if (addr == AW'(OFF_INTVEC)) begin
                sel = SEL_INTVEC;
            end else if (addr == AW'(OFF_ENMASK)) begin
                sel = SEL_ENMASK;
            end
        end
    end

endmodule

// File: rtl/dma_rf_chan.sv
// Module: per-channel register set.
// Holds control/status, control-block address, debug and the six
// descriptor mirror words. Engine updates are applied first and the
// software write second, so software wins a same-cycle collision.
// Assumes wr_cs, wr_cba and wr_dbg are mutually exclusive.
module dma_rf_chan
    import dma_rf_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cs,
    input  logic          wr_cba,
    input  logic          wr_dbg,
    input  logic [DW-1:0] wdata,
    input  logic          st_valid,
    input  logic          st_end,
    input  logic          st_int,
    input  logic          st_err,
    input  logic          st_finish,
    input  logic          st_held,
    input  logic          mr_valid,
    input  logic [DW-1:0] mr_info,
    input  logic [DW-1:0] mr_src,
    input  logic [DW-1:0] mr_dst,
    input  logic [DW-1:0] mr_len,
    input  logic [DW-1:0] mr_stride,
    input  logic [DW-1:0] mr_next,
    input  logic          cb_we,
    input  logic [DW-1:0] cb_addr,
    output logic [DW-1:0] cs,
    output logic [DW-1:0] cba,
    output logic [DW-1:0] dbg,
    output logic [DW-1:0] info,
    output logic [DW-1:0] src,
    output logic [DW-1:0] dst,
    output logic [DW-1:0] len,
    output logic [DW-1:0] stride,
    output logic [DW-1:0] next,
    output logic          start
);
    localparam logic [DW-1:0] RWM = DW'(CS_RW_MASK);

    logic [DW-1:0] cs_q, cs_d, cba_q, cba_d, dbg_q;
    logic [DW-1:0] info_q, src_q, dst_q, len_q, stride_q, next_q;
    logic          start_q, start_d;

    // Next control/status: engine effects, then software reset, W1C and field.
    always_comb begin
        cs_d = cs_q;
        if (st_valid) begin
            if (st_end) cs_d[B_END] = 1'b1;
            if (st_int) cs_d[B_INT] = 1'b1;
            if (st_err) cs_d[B_ERR] = 1'b1;
            cs_d[B_HELD] = st_held;
            if (st_finish) begin
                cs_d[B_ACTIVE] = 1'b0;
                cs_d[B_PAUSED] = 1'b1;
            end
        end
        if (wr_cs) begin
            if (wdata[B_SRST]) cs_d = '0;
            if (wdata[B_END])  cs_d[B_END] = 1'b0;
            if (wdata[B_INT])  cs_d[B_INT] = 1'b0;
            cs_d = (cs_d & ~RWM) | (wdata & RWM);
        end
    end

    // Next control-block address: engine advance, overridden by software.
    always_comb begin
        cba_d = cba_q;
        if (cb_we)                  cba_d = cb_addr;
        if (wr_cs && wdata[B_SRST]) cba_d = '0;
        if (wr_cba)                 cba_d = wdata;
    end

    // Start request when a software write raises ACTIVE.
    always_comb begin
        start_d = wr_cs && !cs_q[B_ACTIVE] && cs_d[B_ACTIVE];
    end

    // Control/status, address, debug and start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            cba_q   <= '0;
            dbg_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cs_q    <= cs_d;
            cba_q   <= cba_d;
            start_q <= start_d;
            if (wr_dbg) dbg_q <= wdata;
        end
    end

    // Descriptor mirror words loaded by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            len_q    <= '0;
            stride_q <= '0;
            next_q   <= '0;
        end else if (mr_valid) begin
            info_q   <= mr_info;
            src_q    <= mr_src;
            dst_q    <= mr_dst;
            len_q    <= mr_len;
            stride_q <= mr_stride;
            next_q   <= mr_next;
        end
    end

    assign cs     = cs_q;
    assign cba    = cba_q;
    assign dbg    = dbg_q;
    assign info   = info_q;
    assign src    = src_q;
    assign dst    = dst_q;
    assign len    = len_q;
    assign stride = stride_q;
    assign next   = next_q;
    assign start  = start_q;

    // R3: a one written to END leaves END clear, even against an engine set (R13).
    p_end_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs && wdata[B_END] |=> !cs_q[B_END]);

    // R4: a one written to INT leaves INT clear.
    p_int_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs && wdata[B_INT] |=> !cs_q[B_INT]);

    // R2: the read/write field takes exactly the written value.
    p_rw_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs |=> ((cs_q ^ $past(wdata)) & RWM) == '0);

    // R2: with no write and no engine update the word holds.
    p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cs && !st_valid |=> $stable(cs_q));

    // R5: the reset bit zeroes the control-block address.
    p_srst_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs && wdata[B_SRST] |=> cba_q == '0);

    // R6: a start pulse appears only with a fresh rise of ACTIVE.
    p_start_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> cs_q[B_ACTIVE] && !$past(cs_q[B_ACTIVE]));

    // R8: mirror words change only on an engine load.
    p_mirror_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_valid |=> $stable(info_q) && $stable(next_q));

endmodule

// File: rtl/dma_rf_readmux.sv
// Module: read data selector.
// Picks the word named by the decoder from the channel arrays or the
// shared vectors. Assumes the channel index is below NCH.
module dma_rf_readmux
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned DW  = 32,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  reg_sel_e                 sel,
    input  logic [CHW-1:0]           chan,
    input  logic [NCH-1:0][DW-1:0]   cs_a,
    input  logic [NCH-1:0][DW-1:0]   cba_a,
    input  logic [NCH-1:0][DW-1:0]   dbg_a,
    input  logic [NCH-1:0][DW-1:0]   info_a,
    input  logic [NCH-1:0][DW-1:0]   src_a,
    input  logic [NCH-1:0][DW-1:0]   dst_a,
    input  logic [NCH-1:0][DW-1:0]   len_a,
    input  logic [NCH-1:0][DW-1:0]   str_a,
    input  logic [NCH-1:0][DW-1:0]   nxt_a,
    input  logic [NCH-1:0]           intvec,
    input  logic [NCH-1:0]           enmask,
    output logic [DW-1:0]            rdata
);
    // Select the addressed word; unknown offsets return zero.
    always_comb begin
        case (sel)
            SEL_CS:     rdata = cs_a[chan];
            SEL_CBA:    rdata = cba_a[chan];
            SEL_INFO:   rdata = info_a[chan];
            SEL_SRC:    rdata = src_a[chan];
            SEL_DST:    rdata = dst_a[chan];
            SEL_LEN:    rdata = len_a[chan];
            SEL_STRIDE: rdata = str_a[chan];
            SEL_NEXT:   rdata = nxt_a[chan];
            SEL_DBG:    rdata = dbg_a[chan];
            SEL_INTVEC: rdata = DW'(intvec);
            SEL_ENMASK: rdata = DW'(enmask);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_regfile.sv
// Module: top of the DMA register file.
// Single-cycle word-access slave with a registered response. Holds the
// shared enable mask and derives the interrupt vector and lines from the
// channels' INT bits. Assumes DW >= 32 and a 12-bit window offset.
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 12,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic           req_win,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rsp_ready,
    output logic [DW-1:0]  rsp_rdata,
    output logic [NCH-1:0] chan_enable,
    output logic [NCH-1:0] start_pulse,
    output logic [NCH-1:0] irq,
    input  logic           eng_stat_valid,
    input  logic [CHW-1:0] eng_chan,
    input  logic           eng_set_end,
    input  logic           eng_set_int,
    input  logic           eng_set_err,
    input  logic           eng_finish,
    input  logic           eng_held,
    input  logic           eng_mirror_valid,
    input  logic [DW-1:0]  eng_info,
    input  logic [DW-1:0]  eng_src,
    input  logic [DW-1:0]  eng_dst,
    input  logic [DW-1:0]  eng_len,
    input  logic [DW-1:0]  eng_stride,
    input  logic [DW-1:0]  eng_next,
    input  logic           eng_cb_we,
    input  logic [DW-1:0]  eng_cb_addr
);
    logic [CHW-1:0]         dec_chan;
    reg_sel_e               dec_sel;
    logic                   wr_go;
    logic [NCH-1:0][DW-1:0] cs_a, cba_a, dbg_a, info_a, src_a, dst_a, len_a, str_a, nxt_a;
    logic [NCH-1:0]         intvec, en_q;
    logic [DW-1:0]          rd_mux, rdata_q;
    logic                   ready_q;

    dma_rf_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .win  (req_win),
        .addr (req_addr),
        .chan (dec_chan),
        .sel  (dec_sel)
    );

    assign wr_go = req_valid && req_write;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit_bus, hit_eng;
        assign hit_bus = wr_go && (dec_chan == CHW'(c));
        assign hit_eng = (eng_chan == CHW'(c));

        dma_rf_chan #(.DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cs     (hit_bus && dec_sel == SEL_CS),
            .wr_cba    (hit_bus && dec_sel == SEL_CBA),
            .wr_dbg    (hit_bus && dec_sel == SEL_DBG),
            .wdata     (req_wdata),
            .st_valid  (eng_stat_valid && hit_eng),
            .st_end    (eng_set_end),
            .st_int    (eng_set_int),
            .st_err    (eng_set_err),
            .st_finish (eng_finish),
            .st_held   (eng_held),
            .mr_valid  (eng_mirror_valid && hit_eng),
            .mr_info   (eng_info),
            .mr_src    (eng_src),
            .mr_dst    (eng_dst),
            .mr_len    (eng_len),
            .mr_stride (eng_stride),
            .mr_next   (eng_next),
            .cb_we     (eng_cb_we && hit_eng),
            .cb_addr   (eng_cb_addr),
            .cs        (cs_a[c]),
            .cba       (cba_a[c]),
            .dbg       (dbg_a[c]),
            .info      (info_a[c]),
            .src       (src_a[c]),
            .dst       (dst_a[c]),
            .len       (len_a[c]),
            .stride    (str_a[c]),
            .next      (nxt_a[c]),
            .start     (start_pulse[c])
        );

        assign intvec[c] = cs_a[c][B_INT];
    end

    dma_rf_readmux #(.NCH(NCH), .DW(DW)) u_rmux (
        .sel    (dec_sel),
        .chan   (dec_chan),
        .cs_a   (cs_a),
        .cba_a  (cba_a),
        .dbg_a  (dbg_a),
        .info_a (info_a),
        .src_a  (src_a),
        .dst_a  (dst_a),
        .len_a  (len_a),
        .str_a  (str_a),
        .nxt_a  (nxt_a),
        .intvec (intvec),
        .enmask (en_q),
        .rdata  (rd_mux)
    );

    // Shared enable mask, written only through its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (wr_go && dec_sel == SEL_ENMASK) begin
            en_q <= req_wdata[NCH-1:0];
        end
    end

    // One-cycle registered response: ready strobe and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= req_valid;
            rdata_q <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    assign rsp_ready   = ready_q;
    assign rsp_rdata   = rdata_q;
    assign chan_enable = en_q;
    assign irq         = intvec;

    // R12: every request is answered in the next cycle.
    p_ack_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    // R12: no response without a request.
    p_no_spurious_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    // R12: write responses carry zero data.
    p_write_zero_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rsp_rdata == '0);

    // R4: clearing INT drops that channel's interrupt line.
    p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && dec_sel == SEL_CS && req_wdata[B_INT] |=> !irq[$past(dec_chan)]);

    // R11: an enable write is reflected on chan_enable next cycle.
    p_enable_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && dec_sel == SEL_ENMASK |=> chan_enable == $past(req_wdata[NCH-1:0]));

endmodule

// File: tb/dma_regfile_tb.sv
`timescale 1ns/1ps
module dma_regfile_tb;
    localparam logic [31:0] RWM = 32'h30FF_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_win = 0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic [15:0] chan_enable, start_pulse, irq;
    logic        eng_stat_valid = 0, eng_set_end = 0, eng_set_int = 0, eng_set_err = 0;
    logic        eng_finish = 0, eng_held = 0, eng_mirror_valid = 0, eng_cb_we = 0;
    logic [3:0]  eng_chan = '0;
    logic [31:0] eng_info = '0, eng_src = '0, eng_dst = '0, eng_len = '0;
    logic [31:0] eng_stride = '0, eng_next = '0, eng_cb_addr = '0;

    always #2.5 clk = ~clk;

    dma_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .chan_enable(chan_enable), .start_pulse(start_pulse), .irq(irq),
        .eng_stat_valid(eng_stat_valid), .eng_chan(eng_chan),
        .eng_set_end(eng_set_end), .eng_set_int(eng_set_int), .eng_set_err(eng_set_err),
        .eng_finish(eng_finish), .eng_held(eng_held),
        .eng_mirror_valid(eng_mirror_valid), .eng_info(eng_info), .eng_src(eng_src),
        .eng_dst(eng_dst), .eng_len(eng_len), .eng_stride(eng_stride), .eng_next(eng_next),
        .eng_cb_we(eng_cb_we), .eng_cb_addr(eng_cb_addr)
    );

    // Bench model of the software-visible state.
    logic [31:0] m_cs [16];
    logic [31:0] m_cba[16];
    logic [31:0] m_dbg[16];
    logic [31:0] m_mir[16][6];
    logic [15:0] m_en;
    logic [31:0] g_mir[6];

    int errors = 0;
    int checks = 0;
    bit done = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 none, 1 channel register, 2 interrupt vector, 3 enable mask
    function automatic int decode(input bit win, input logic [11:0] a,
                                  output int ch, output int off);
        ch = 0; off = 0;
        if (a[1:0] != 0) return 0;
        if (win) begin ch = 15; off = int'(a[7:0]); end
        else if (a < 12'hF00) begin ch = int'(a[11:8]); off = int'(a[7:0]); end
        else if (a == 12'hFE0) return 2;
        else if (a == 12'hFF0) return 3;
        else return 0;
        if (off > 32) return 0;
        return 1;
    endfunction

    function automatic logic [15:0] m_intvec();
        logic [15:0] v;
        for (int c = 0; c < 16; c++) v[c] = m_cs[c][2];
        return v;
    endfunction

    function automatic logic [31:0] m_read(input bit win, input logic [11:0] a);
        int ch, off, k;
        k = decode(win, a, ch, off);
        if (k == 2) return {16'h0, m_intvec()};
        if (k == 3) return {16'h0, m_en};
        if (k == 0) return 32'h0;
        case (off)
            0:  return m_cs[ch];
            4:  return m_cba[ch];
            32: return m_dbg[ch];
            8, 12, 16, 20, 24, 28: return m_mir[ch][(off - 8) / 4];
            default: return 32'h0;
        endcase
    endfunction

    // One cycle of stimulus: optional bus access and optional engine traffic.
    // sf = {held, finish, err, int, end}
    task automatic step(input bit bv, input bit bw, input bit bwin,
                        input logic [11:0] a, input logic [31:0] d,
                        input bit sv, input bit mv, input bit cbw, input int ech,
                        input logic [4:0] sf, input logic [31:0] cbv, input string tag);
        logic [31:0] exp_rd, oldcs, r;
        logic [15:0] exp_st;
        int ch, off, k;
        exp_rd = (bv && !bw) ? m_read(bwin, a) : 32'h0;
        exp_st = '0;
        k = decode(bwin, a, ch, off);
        oldcs = m_cs[ch];
        if (sv) begin
            if (sf[0]) m_cs[ech][1] = 1'b1;
            if (sf[1]) m_cs[ech][2] = 1'b1;
            if (sf[2]) m_cs[ech][8] = 1'b1;
            m_cs[ech][5] = sf[4];
            if (sf[3]) begin m_cs[ech][0] = 1'b0; m_cs[ech][4] = 1'b1; end
        end
        if (mv) for (int i = 0; i < 6; i++) m_mir[ech][i] = g_mir[i];
        if (cbw) m_cba[ech] = cbv;
        if (bv && bw) begin
            if (k == 3) m_en = d[15:0];
            else if (k == 1 && off == 0) begin
                r = m_cs[ch];
                if (d[31]) begin r = 32'h0; m_cba[ch] = 32'h0; end
                if (d[1]) r[1] = 1'b0;
                if (d[2]) r[2] = 1'b0;
                r = (r & ~RWM) | (d & RWM);
                m_cs[ch] = r;
                if (!oldcs[0] && r[0]) exp_st[ch] = 1'b1;
            end
            else if (k == 1 && off == 4) m_cba[ch] = d;
            else if (k == 1 && off == 32) m_dbg[ch] = d;
        end
        @(negedge clk);
        req_valid = bv; req_write = bw; req_win = bwin; req_addr = a; req_wdata = d;
        eng_stat_valid = sv; eng_mirror_valid = mv; eng_cb_we = cbw;
        eng_chan = 4'(ech); eng_cb_addr = cbv;
        {eng_held, eng_finish, eng_set_err, eng_set_int, eng_set_end} = sf;
        eng_info = g_mir[0]; eng_src = g_mir[1]; eng_dst = g_mir[2];
        eng_len = g_mir[3]; eng_stride = g_mir[4]; eng_next = g_mir[5];
        @(negedge clk);
        req_valid = 0; req_write = 0;
        eng_stat_valid = 0; eng_mirror_valid = 0; eng_cb_we = 0;
        check("R12", "ready", {31'h0, rsp_ready}, {31'h0, bv});
        if (bv) check(tag, "rdata", rsp_rdata, exp_rd);
        check("R6", "start_pulse", {16'h0, start_pulse}, {16'h0, exp_st});
        check("R10", "irq", {16'h0, irq}, {16'h0, m_intvec()});
        check("R11", "chan_enable", {16'h0, chan_enable}, {16'h0, m_en});
    endtask

    task automatic wr(input bit win, input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1, 1, win, a, d, 0, 0, 0, 0, 5'h0, 32'h0, tag);
    endtask

    task automatic rd(input bit win, input logic [11:0] a, input string tag);
        step(1, 0, win, a, 32'h0, 0, 0, 0, 0, 5'h0, 32'h0, tag);
    endtask

    function automatic logic [11:0] chan_addr(input int ch, input int off);
        return (ch == 15) ? 12'(off) : 12'((ch << 8) | off);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            m_cs[c] = 0; m_cba[c] = 0; m_dbg[c] = 0;
            for (int i = 0; i < 6; i++) m_mir[c][i] = 0;
        end
        for (int i = 0; i < 6; i++) g_mir[i] = 0;
        m_en = 16'hFFFF;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R14: reset state
        check("R14", "start_pulse", {16'h0, start_pulse}, 32'h0);
        check("R14", "irq", {16'h0, irq}, 32'h0);
        check("R14", "chan_enable", {16'h0, chan_enable}, 32'h0000FFFF);
        rd(0, 12'h300, "R14");
        rd(0, 12'h704, "R14");
        rd(0, 12'hFE0, "R14");
        rd(0, 12'hFF0, "R14");
        rd(1, 12'h000, "R14");

        // R6: start on rise of ACTIVE only
        wr(0, chan_addr(3, 0), 32'h1, "R6");
        wr(0, chan_addr(3, 0), 32'h1, "R6");
        rd(0, chan_addr(3, 0), "R6");

        // R2 / R5: all-ones write leaves only the masked field, bits 31:30 read 0
        wr(0, chan_addr(5, 0), 32'hFFFF_FFFF, "R5");
        rd(0, chan_addr(5, 0), "R2");
        check("R5", "cs bits31:30", {30'h0, m_cs[5][31:30]}, 32'h0);

        // R9: engine sets END/INT/ERR/HELD; R10 vector
        step(0, 0, 0, 12'h0, 32'h0, 1, 0, 0, 5, 5'b10111, 32'h0, "R9");
        rd(0, chan_addr(5, 0), "R9");
        rd(0, 12'hFE0, "R10");
        wr(0, 12'hFE0, 32'h0, "R10");
        rd(0, 12'hFE0, "R10");
        // R4 then R3
        wr(0, chan_addr(5, 0), 32'h4 | 32'h1, "R4");
        rd(0, chan_addr(5, 0), "R4");
        wr(0, chan_addr(5, 0), 32'h2 | 32'h1, "R3");
        rd(0, chan_addr(5, 0), "R3");
        // R9: finish clears ACTIVE and sets PAUSED
        step(0, 0, 0, 12'h0, 32'h0, 1, 0, 0, 5, 5'b01000, 32'h0, "R9");
        rd(0, chan_addr(5, 0), "R9");

        // R7: address and debug registers
        wr(0, chan_addr(2, 4), 32'hDEAD_BEEC, "R7");
        wr(0, chan_addr(2, 32), 32'h1234_5678, "R7");
        rd(0, chan_addr(2, 4), "R7");
        rd(0, chan_addr(2, 32), "R7");
        // R5: reset bit clears address
        wr(0, chan_addr(2, 0), 32'h8000_0000, "R5");
        rd(0, chan_addr(2, 4), "R5");

        // R11: enable mask
        wr(0, 12'hFF0, 32'hFFFF_00A5, "R11");
        rd(0, 12'hFF0, "R11");

        // R1: channel 15 only through its own window; unknown offsets
        wr(1, 12'h004, 32'hCAFE_0010, "R1");
        rd(1, 12'h004, "R1");
        rd(0, 12'hF04, "R1");
        wr(0, 12'hF04, 32'h5555_5555, "R1");
        rd(1, 12'h004, "R1");
        wr(0, chan_addr(4, 6), 32'hFFFF_FFFF, "R1");
        rd(0, chan_addr(4, 4), "R1");
        rd(0, chan_addr(4, 36), "R1");
        wr(0, 12'hF80, 32'hFFFF_FFFF, "R1");
        rd(0, 12'hFF0, "R1");

        // R8: mirror words
        for (int i = 0; i < 6; i++) g_mir[i] = 32'hA000_0000 + 32'(i * 17);
        step(0, 0, 0, 12'h0, 32'h0, 0, 1, 0, 15, 5'h0, 32'h0, "R8");
        for (int i = 0; i < 6; i++) rd(1, 12'(8 + 4 * i), "R8");
        wr(1, 12'h008, 32'h0, "R8");
        rd(1, 12'h008, "R8");

        // R13: same-cycle collisions
        step(1, 1, 0, chan_addr(7, 0), 32'h6, 1, 0, 0, 7, 5'b00011, 32'h0, "R13");
        rd(0, chan_addr(7, 0), "R13");
        wr(0, chan_addr(7, 0), 32'h1, "R13");
        step(1, 1, 0, chan_addr(7, 0), 32'h1, 1, 0, 0, 7, 5'b01000, 32'h0, "R13");
        rd(0, chan_addr(7, 0), "R13");
        step(1, 1, 0, chan_addr(7, 4), 32'h0000_0100, 0, 0, 1, 7, 5'h0, 32'h0000_0200, "R13");
        rd(0, chan_addr(7, 4), "R13");
        step(0, 0, 0, 12'h0, 32'h0, 0, 0, 1, 7, 5'h0, 32'h0000_0300, "R9");
        rd(0, chan_addr(7, 4), "R9");

        // Random mix of bus and engine traffic.
        for (int it = 0; it < 600; it++) begin
            int ch, off, op;
            logic [31:0] d;
            ch  = int'($urandom % 16);
            off = int'($urandom % 9) * 4;
            op  = int'($urandom % 6);
            d   = $urandom;
            if (($urandom % 8) != 0) d[31] = 1'b0;
            for (int i = 0; i < 6; i++) g_mir[i] = $urandom;
            case (op)
                0: wr(ch == 15, chan_addr(ch, 0), d, "R2");
                1: wr(ch == 15, chan_addr(ch, off), d, "R7");
                2: rd(ch == 15, chan_addr(ch, off), "R1");
                3: step(0, 0, 0, 12'h0, 32'h0, 1, $urandom % 2, $urandom % 2,
                        int'($urandom % 16), 5'($urandom), $urandom, "R9");
                4: step(1, ($urandom % 2), ch == 15, chan_addr(ch, off), d,
                        1, 1, $urandom % 2, ch, 5'($urandom), $urandom, "R13");
                default: begin
                    if (($urandom % 4) == 0) wr(0, 12'hFF0, d, "R11");
                    else rd(0, (($urandom % 2) == 0) ? 12'hFE0 : 12'(($urandom % 4096)), "R10");
                end
            endcase
        end

        // Final sweep of every channel's status and address words.
        for (int c = 0; c < 16; c++) begin
            rd(c == 15, chan_addr(c, 0), "R2");
            rd(c == 15, chan_addr(c, 4), "R7");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule